// File: doc/BRIEF.md
# Audio Interrupt Aggregator

This block merges every interrupt source of a multi-stream audio controller into one 32-bit status word and a single interrupt request. The sources are:

- the sticky completion flags of up to eight streams;
- the sticky state-change flags of the attached codecs, each gated by a wake-enable mask;
- the interrupt and overrun flags of the response ring.

A host-written control word enables status bits one by one. Its top bit is the master enable.

Status bit 31 summarises every enabled source. Bit 30 summarises the controller-level sources. Bits 7:0 carry the stream flags. The request leaves the block in one of two ways:

- in pin mode, as a level on `irq_pin`;
- in message mode, as a one-cycle `msg_pulse` each time the level rises.

The host clears stream flags by writing ones to the status word. It clears codec state-change flags through their own write-one-to-clear port. After reset, the state-change flags hold the presence mask of the attached codecs.

Top module: `audio_irq_aggregator`

## Requirements
- R1: While `rst_n` is low (synchronous reset), `int_ctl` and all stream flags clear, the internal level history clears, and `chg_sts` loads `codec_present`. After reset the outputs are therefore `int_ctl`=0, `irq_pin`=0 and `msg_pulse`=0.
- R2: A high `strm_done_ev[i]` in a cycle sets stream flag i at the next clock edge. The flag reads in `int_sts[i]` and stays set until cleared.
- R3: A status write (`sts_w1c_we`) clears stream flag i where `sts_w1c_data[i]` is 1. An event on the same stream in the same cycle wins over the clear. Ones written to bits 31:8 change nothing.
- R4: `int_sts[30]` is 1 exactly when at least one of these holds:
  - `resp_irq` is high;
  - `resp_ovr` is high;
  - `chg_sts & wake_mask` is nonzero.
- R5: `int_sts[31]` is 1 exactly when `int_sts[30:0] & int_ctl[30:0]` is nonzero. `int_sts[29:8]` always reads 0.
- R6: A control write (`ctl_we`) stores `ctl_wdata & 32'hC00000FF` into `int_ctl` at the next clock edge.
- R7: With `msg_mode`=0, `irq_pin` equals `int_sts[31] & int_ctl[31]` in the same cycle.
- R8: With `msg_mode`=1, `irq_pin` stays 0 and `msg_pulse` is high for exactly one cycle each time `int_sts[31] & int_ctl[31]` goes from 0 to 1. It does not pulse again while that level stays high.
- R9: A high `codec_wake_ev[j]` sets `chg_sts[j]` at the next edge. A `chg_clr_we` write clears the bits set in `chg_clr_data`. A set wins over a clear on the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| msg_mode | input | 1 | 1 selects message delivery, 0 selects the level pin |
| codec_present | input | NCODEC | Presence mask loaded into the state-change flags during reset |
| codec_wake_ev | input | NCODEC | One-cycle state-change events per codec address |
| chg_clr_we | input | 1 | Write strobe for clearing state-change flags |
| chg_clr_data | input | NCODEC | Ones clear the matching state-change flags |
| wake_mask | input | NCODEC | Wake enable per codec address |
| resp_irq | input | 1 | Response-ring interrupt flag |
| resp_ovr | input | 1 | Response-ring overrun flag |
| strm_done_ev | input | NSTREAM | One-cycle buffer-completion events per stream |
| sts_w1c_we | input | 1 | Write strobe for the status word |
| sts_w1c_data | input | 32 | Write-one-to-clear data for the status word |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 32 | Control write data |
| int_sts | output | 32 | Interrupt status word |
| int_ctl | output | 32 | Interrupt control word |
| chg_sts | output | NCODEC | Codec state-change flags |
| irq_pin | output | 1 | Level interrupt (pin mode) |
| msg_pulse | output | 1 | One-cycle message request (message mode) |

## Verification
The properties assume that every input changes only between clock edges and holds stable across the edge that samples it. They also assume `msg_mode` is stable around a rising level, so that a pulse is tied to that rise. The stimulus drives all inputs one time unit after a rising edge and holds event and strobe inputs for exactly one cycle. It changes `msg_mode` only in the same drive slot, so every property sees clean single-cycle strobes.

// File: rtl/audio_irq_pkg.sv
package audio_irq_pkg;

  localparam int STS_W        = 32;
  localparam int MAX_STREAMS  = 8;
  localparam int CTRL_BIT     = 30;
  localparam int GLOBAL_BIT   = 31;
  localparam logic [STS_W-1:0] W1C_MASK  = 32'hC00000FF;
  localparam logic [STS_W-1:0] CTL_WMASK = 32'hC00000FF;

  // Controller-level summary: ring flags or any enabled codec change.
  function automatic logic ctrl_summary(input logic ring_irq, input logic ring_ovr,
                                        input logic codec_hit);
    return ring_irq | ring_ovr | codec_hit;
  endfunction

  // Lower 31 bits of the status word (global bit left at zero).
  function automatic logic [STS_W-1:0] compose_status(input logic [MAX_STREAMS-1:0] strm,
                                                      input logic ctrl);
    logic [STS_W-1:0] s;
    s = '0;
    s[MAX_STREAMS-1:0] = strm;
    s[CTRL_BIT] = ctrl;
    return s;
  endfunction

  // Global summary: any enabled status bit below the global bit.
  function automatic logic global_summary(input logic [STS_W-1:0] s,
                                          input logic [STS_W-1:0] en);
    return |(s[GLOBAL_BIT-1:0] & en[GLOBAL_BIT-1:0]);
  endfunction

endpackage

// File: rtl/aif_flag_bank.sv
module aif_flag_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] init_val,
  input  logic [W-1:0] set_ev,
  input  logic         clr_we,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic q;
    always_ff @(posedge clk) begin
      if (!rst_n)           q <= init_val[i];
      else if (set_ev[i])   q <= 1'b1;
      else if (clr_we && clr_mask[i]) q <= 1'b0;
    end
    assign flags[i] = q;
  end

endmodule

// File: rtl/aif_status.sv
module aif_status
  import audio_irq_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input  logic [NSTREAM-1:0] strm_flags,
  input  logic [NCODEC-1:0]  chg_flags,
  input  logic [NCODEC-1:0]  wake_mask,
  input  logic               resp_irq,
  input  logic               resp_ovr,
  input  logic [STS_W-1:0]   int_ctl,
  output logic [STS_W-1:0]   int_sts,
  output logic               irq_level
);

  logic [MAX_STREAMS-1:0] strm_pad;
  logic                   codec_hit;
  logic                   ctrl_sum;
  logic [STS_W-1:0]       low_sts;
  logic                   glob;

  always_comb begin
    strm_pad = '0;
    strm_pad[NSTREAM-1:0] = strm_flags;
  end

  assign codec_hit = |(chg_flags & wake_mask);
  assign ctrl_sum  = ctrl_summary(resp_irq, resp_ovr, codec_hit);
  assign low_sts   = compose_status(strm_pad, ctrl_sum);
  assign glob      = global_summary(low_sts, int_ctl);

  always_comb begin
    int_sts = low_sts;
    int_sts[GLOBAL_BIT] = glob;
  end

  assign irq_level = int_sts[GLOBAL_BIT] & int_ctl[GLOBAL_BIT];

endmodule

// File: rtl/aif_irq_out.sv
module aif_irq_out (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic msg_mode,
  output logic irq_pin,
  output logic msg_pulse
);

  logic level_q;

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign irq_pin   = level & ~msg_mode;
  assign msg_pulse = msg_mode & level & ~level_q;

endmodule

// File: rtl/audio_irq_aggregator.sv
module audio_irq_aggregator
  import audio_irq_pkg::*;
#(
  parameter int NSTREAM = 8,
  parameter int NCODEC  = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               msg_mode,
  input  logic [NCODEC-1:0]  codec_present,
  input  logic [NCODEC-1:0]  codec_wake_ev,
  input  logic               chg_clr_we,
  input  logic [NCODEC-1:0]  chg_clr_data,
  input  logic [NCODEC-1:0]  wake_mask,
  input  logic               resp_irq,
  input  logic               resp_ovr,
  input  logic [NSTREAM-1:0] strm_done_ev,
  input  logic               sts_w1c_we,
  input  logic [31:0]        sts_w1c_data,
  input  logic               ctl_we,
  input  logic [31:0]        ctl_wdata,
  output logic [31:0]        int_sts,
  output logic [31:0]        int_ctl,
  output logic [NCODEC-1:0]  chg_sts,
  output logic               irq_pin,
  output logic               msg_pulse
);

  localparam logic [NSTREAM-1:0] STRM_ZERO = '0;

  logic [STS_W-1:0]   sts_clr;
  logic [NSTREAM-1:0] strm_flags;
  logic [STS_W-1:0]   ctl_q;
  logic               irq_level;

  assign sts_clr = sts_w1c_data & W1C_MASK;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctl_q <= '0;
    else if (ctl_we) ctl_q <= ctl_wdata & CTL_WMASK;
  end
  assign int_ctl = ctl_q;

  aif_flag_bank #(.W(NSTREAM)) u_strm (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_val (STRM_ZERO),
    .set_ev   (strm_done_ev),
    .clr_we   (sts_w1c_we),
    .clr_mask (sts_clr[NSTREAM-1:0]),
    .flags    (strm_flags)
  );

  aif_flag_bank #(.W(NCODEC)) u_chg (
    .clk      (clk),
    .rst_n    (rst_n),
    .init_val (codec_present),
    .set_ev   (codec_wake_ev),
    .clr_we   (chg_clr_we),
    .clr_mask (chg_clr_data),
    .flags    (chg_sts)
  );

  aif_status #(.NSTREAM(NSTREAM), .NCODEC(NCODEC)) u_sts (
    .strm_flags (strm_flags),
    .chg_flags  (chg_sts),
    .wake_mask  (wake_mask),
    .resp_irq   (resp_irq),
    .resp_ovr   (resp_ovr),
    .int_ctl    (ctl_q),
    .int_sts    (int_sts),
    .irq_level  (irq_level)
  );

  aif_irq_out u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .level     (irq_level),
    .msg_mode  (msg_mode),
    .irq_pin   (irq_pin),
    .msg_pulse (msg_pulse)
  );

endmodule

// File: rtl/aif_checker.sv
module aif_checker #(
  parameter int NSTREAM = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               msg_mode,
  input logic [NSTREAM-1:0] strm_done_ev,
  input logic               sts_w1c_we,
  input logic [31:0]        sts_w1c_data,
  input logic               ctl_we,
  input logic [31:0]        ctl_wdata,
  input logic [31:0]        int_sts,
  input logic [31:0]        int_ctl,
  input logic               irq_pin,
  input logic               msg_pulse,
  input logic               irq_level
);

  assert_stream_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strm_done_ev != '0) |=>
      ((int_sts[NSTREAM-1:0] & $past(strm_done_ev)) == $past(strm_done_ev)));

  assert_stream_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sts_w1c_we |=>
      ((int_sts[NSTREAM-1:0] & $past(sts_w1c_data[NSTREAM-1:0] & ~strm_done_ev)) == '0));

  assert_ctl_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_we |=> (int_ctl == ($past(ctl_wdata) & 32'hC00000FF)));

  assert_pin_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pin |-> (int_sts[31] && int_ctl[31] && !msg_mode));

  assert_pin_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |-> !irq_pin);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |=> !msg_pulse);

  assert_pulse_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> irq_level);

endmodule

bind audio_irq_aggregator aif_checker #(.NSTREAM(NSTREAM)) u_chk (.*);

// File: tb/sim_audio_irq_aggregator.sv
`timescale 1ns/1ps
module sim_audio_irq_aggregator;
  localparam int NS = 8;
  localparam int NC = 15;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, msg_mode, chg_clr_we, resp_irq, resp_ovr, sts_w1c_we, ctl_we;
  logic [NC-1:0] codec_present, codec_wake_ev, chg_clr_data, wake_mask, chg_sts;
  logic [NS-1:0] strm_done_ev;
  logic [31:0] sts_w1c_data, ctl_wdata, int_sts, int_ctl;
  logic irq_pin, msg_pulse;

  audio_irq_aggregator #(.NSTREAM(NS), .NCODEC(NC)) u0 (
    .clk(clk), .rst_n(rst_n), .msg_mode(msg_mode), .codec_present(codec_present),
    .codec_wake_ev(codec_wake_ev), .chg_clr_we(chg_clr_we), .chg_clr_data(chg_clr_data),
    .wake_mask(wake_mask), .resp_irq(resp_irq), .resp_ovr(resp_ovr),
    .strm_done_ev(strm_done_ev), .sts_w1c_we(sts_w1c_we), .sts_w1c_data(sts_w1c_data),
    .ctl_we(ctl_we), .ctl_wdata(ctl_wdata), .int_sts(int_sts), .int_ctl(int_ctl),
    .chg_sts(chg_sts), .irq_pin(irq_pin), .msg_pulse(msg_pulse)
  );

  int n_chk = 0, n_fail = 0, n_cyc = 0;
  bit cmp_en = 0, done = 0;

  // Behavioural reference state
  logic [NS-1:0] m_strm;
  logic [NC-1:0] m_chg;
  logic [31:0]   m_ctl;
  logic          m_lq;

  function automatic logic [31:0] ref_sts();
    logic [31:0] s = 32'd0;
    bit ctrl = resp_irq || resp_ovr;
    for (int i = 0; i < NS; i++) if (m_strm[i]) s[i] = 1'b1;
    for (int j = 0; j < NC; j++) if (m_chg[j] && wake_mask[j]) ctrl = 1;
    s[30] = ctrl;
    for (int k = 0; k < 31; k++) if (s[k] && m_ctl[k]) s[31] = 1'b1;
    return s;
  endfunction

  function automatic logic ref_lvl();
    logic [31:0] s = ref_sts();
    return s[31] && m_ctl[31];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_strm <= '0; m_chg <= codec_present; m_ctl <= '0; m_lq <= 1'b0;
    end else begin
      m_lq <= ref_lvl();
      for (int i = 0; i < NS; i++)
        if (strm_done_ev[i]) m_strm[i] <= 1'b1;
        else if (sts_w1c_we && sts_w1c_data[i]) m_strm[i] <= 1'b0;
      for (int j = 0; j < NC; j++)
        if (codec_wake_ev[j]) m_chg[j] <= 1'b1;
        else if (chg_clr_we && chg_clr_data[j]) m_chg[j] <= 1'b0;
      if (ctl_we) m_ctl <= ctl_wdata & 32'hC00000FF;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk("R2 R3 R4 R5 sts", int_sts, ref_sts());
      chk("R6 ctl", int_ctl, m_ctl);
      chk("R9 chg", 32'(chg_sts), 32'(m_chg));
      chk("R7 pin", 32'(irq_pin), 32'(ref_lvl() && !msg_mode));
      chk("R8 pulse", 32'(msg_pulse), 32'(ref_lvl() && msg_mode && !m_lq));
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected<=%0d", n_cyc, 100000);
      summary();
    end
  end

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic wr_ctl(input logic [31:0] v);
    ctl_we = 1; ctl_wdata = v; cyc(); ctl_we = 0;
  endtask

  initial begin
    rst_n = 0; msg_mode = 0; codec_present = 15'h0005; codec_wake_ev = '0;
    chg_clr_we = 0; chg_clr_data = '0; wake_mask = '0; resp_irq = 0; resp_ovr = 0;
    strm_done_ev = '0; sts_w1c_we = 0; sts_w1c_data = '0; ctl_we = 0; ctl_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1; cmp_en = 1; #1;
    // R1 reset state
    chk("R1 chg", 32'(chg_sts), 32'h5);
    chk("R1 ctl", int_ctl, 32'h0);
    chk("R1 sts", int_sts, 32'h0);
    chk("R1 pin", 32'(irq_pin), 32'h0);
    chk("R1 pulse", 32'(msg_pulse), 32'h0);

    // R9 clear, then set wins over clear
    chg_clr_we = 1; chg_clr_data = 15'h0001; cyc(); chg_clr_we = 0; #1;
    chk("R9 clear", 32'(chg_sts), 32'h4);
    codec_wake_ev = 15'h0008; chg_clr_we = 1; chg_clr_data = 15'h0008; cyc();
    codec_wake_ev = '0; chg_clr_we = 0; #1;
    chk("R9 set wins", 32'(chg_sts), 32'hC);

    // R6 control write mask
    wr_ctl(32'hFFFF_FFFF); #1;
    chk("R6 mask", int_ctl, 32'hC00000FF);

    // R2 stream flag set, R7 pin
    strm_done_ev = 8'h20; cyc(); strm_done_ev = '0; #1;
    chk("R2 set", int_sts, 32'h80000020);
    chk("R7 pin high", 32'(irq_pin), 32'h1);

    // R3 writes to bits 31:8 ignored; set wins; clear
    sts_w1c_we = 1; sts_w1c_data = 32'hC000FF00; cyc(); sts_w1c_we = 0; #1;
    chk("R3 upper ignored", int_sts, 32'h80000020);
    sts_w1c_we = 1; sts_w1c_data = 32'h20; strm_done_ev = 8'h20; cyc();
    sts_w1c_we = 0; strm_done_ev = '0; #1;
    chk("R3 set wins", int_sts, 32'h80000020);
    sts_w1c_we = 1; sts_w1c_data = 32'h20; cyc(); sts_w1c_we = 0; #1;
    chk("R3 clear", int_sts, 32'h0);
    chk("R7 pin low", 32'(irq_pin), 32'h0);

    // R4 controller summary sources
    wake_mask = 15'h0004; #1;
    chk("R4 codec", int_sts, 32'hC0000000);
    wake_mask = 15'h0001; #1;
    chk("R4 masked codec", int_sts, 32'h0);
    resp_ovr = 1; #1;
    chk("R4 overrun", int_sts, 32'hC0000000);
    resp_ovr = 0; resp_irq = 1; #1;
    chk("R4 ring irq", int_sts, 32'hC0000000);

    // R5 global needs an enabled lower bit
    wr_ctl(32'h8000_0001); #1;
    chk("R5 not enabled", int_sts, 32'h40000000);
    chk("R7 pin off", 32'(irq_pin), 32'h0);
    resp_irq = 0;

    // R8 message mode: one pulse per rise
    msg_mode = 1; strm_done_ev = 8'h01; cyc(); strm_done_ev = '0; #1;
    chk("R8 pulse", 32'(msg_pulse), 32'h1);
    chk("R8 pin quiet", 32'(irq_pin), 32'h0);
    cyc();
    chk("R8 no repeat", 32'(msg_pulse), 32'h0);
    sts_w1c_we = 1; sts_w1c_data = 32'h1; cyc(); sts_w1c_we = 0;
    strm_done_ev = 8'h01; cyc(); strm_done_ev = '0; #1;
    chk("R8 second pulse", 32'(msg_pulse), 32'h1);
    sts_w1c_we = 1; sts_w1c_data = 32'h1; cyc(); sts_w1c_we = 0;
    msg_mode = 0;

    // R5 R7 sweep of enables against sources
    for (int c = 0; c < 32; c++) begin
      logic c31, c30, c0, ri, s0, e31;
      {c31, c30, c0, ri, s0} = 5'(c);
      wr_ctl({c31, c30, 29'd0, c0});
      if (s0) strm_done_ev = 8'h01; else begin sts_w1c_we = 1; sts_w1c_data = 32'h1; end
      cyc(); strm_done_ev = '0; sts_w1c_we = 0;
      resp_irq = ri; #1;
      e31 = (c30 & ri) | (c0 & s0);
      chk("R5 sweep", 32'(int_sts[31]), 32'(e31));
      chk("R7 sweep", 32'(irq_pin), 32'(e31 & c31));
    end

    // Random traffic, compared every cycle
    for (int n = 0; n < 1500; n++) begin
      ctl_we = ($urandom % 8) == 0; ctl_wdata = $urandom;
      if (($urandom % 32) == 0) msg_mode = ~msg_mode;
      strm_done_ev = ($urandom % 4 == 0) ? NS'($urandom) : '0;
      codec_wake_ev = ($urandom % 4 == 0) ? NC'($urandom) : '0;
      sts_w1c_we = ($urandom % 3) == 0; sts_w1c_data = $urandom;
      chg_clr_we = ($urandom % 3) == 0; chg_clr_data = NC'($urandom);
      wake_mask = NC'($urandom); resp_irq = ($urandom % 5) == 0; resp_ovr = ($urandom % 7) == 0;
      cyc();
    end

    ctl_we = 0; sts_w1c_we = 0; chg_clr_we = 0; strm_done_ev = '0; codec_wake_ev = '0;
    cyc();
    cmp_en = 0; done = 1;
    summary();
  end
endmodule